// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between memory locations on behalf of peripherals and software, sharing one 16-bit data bus and one 20-bit address bus with a processor. It has two independent channels. A request on a channel arms that channel. The controller then asks the bus arbiter for the bus and, once the grant arrives, takes it for exactly one read cycle and one write cycle. Between the two cycles the data sits in an internal latch. One accepted request moves one byte or one 16-bit word.

A request comes from one of two places. Software can set a trigger bit through the configuration port. A peripheral event line can also raise it, picked from a 32-line request vector by a 5-bit select value per channel. Each channel keeps fixed base addresses for source and destination. It also keeps an advancing offset that is added to whichever side is set to increment. A 16-bit counter with a reload value ends a run of transfers: the channel disables itself, pulses its done output and restores the counter, ready for the next run.

Requests do not pass through any interrupt masking, and the controller never touches peripheral flags. A channel holds only one pending request, so requests that arrive before service begins count as a single transfer.

Top module: `dual_dma_engine`

## Requirements
- R1: After reset, `bus_req`, `mem_rd`, `mem_wr` and `done` are low. Both channels are disabled, so request lines cause no bus activity.
- R2: An accepted request raises `bus_req` and holds it until its transfer ends. Nothing is driven on the memory port until `bus_gnt` is high. Then exactly one `mem_rd` cycle at the source address is followed directly by one `mem_wr` cycle at the destination address, carrying the data read.
- R3: A request from any source that reaches a disabled channel is discarded and causes no transfer, now or later. Clearing the enable bit also drops any pending request.
- R4: A peripheral request reaches a channel only on `req_in[k]`, where k is the channel's 5-bit select value (field code 1, bits [4:0]). Other request lines have no effect on that channel.
- R5: Any number of requests that arrive between a channel being armed and the start of its read cycle produce a single transfer.
- R6: Control bit 1 chooses the transfer size. When it is 0 (byte), `mem_byte` is 1, the written data is the low byte of the read data with the upper byte zero, and the step is 1. When it is 1 (word), the full 16 bits move and the step is 2.
- R7: Control bit 2 makes the read address source base plus offset, and control bit 3 makes the write address destination base plus offset. When a bit is clear, that side stays at its base address. The offset starts at 0 and grows by the step after each transfer if either bit is set.
- R8: The counter is written together with its reload value (field code 5). A transfer made when the counter reads 1 is the last one: the channel clears its enable bit, `done[ch]` is high for exactly the one cycle after that write cycle, the counter returns to the reload value and the offset returns to 0.
- R9: If both channels are pending in the same idle cycle, channel 0 is served first.
- R10: A configuration write (`cfg_wr`) selects the channel with `cfg_ch` and the field with `cfg_field`. The field codes are 0 control, 1 select, 2 source base, 3 destination base, 4 offset and 5 counter plus reload. The control bits are bit0 enable, bit1 word, bit2 source increment, bit3 destination increment and bit4 software trigger. Setting the trigger arms the channel if the same write leaves it enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_data | input | 20 | Write data |
| req_in | input | 32 | Peripheral request strobes |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 20 | Memory address |
| mem_rd | output | 1 | Read cycle |
| mem_wr | output | 1 | Write cycle |
| mem_byte | output | 1 | 1 for a byte transfer, 0 for a word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the read cycle |
| done | output | 2 | Per-channel end-of-run pulse |

## Verification
The hardest situation to reach from the ports is the merging of several requests into one transfer, together with the same-cycle contention between the channels. Both depend on requests piling up before service starts. To get there, the bench holds back the grant while it pulses a peripheral line three times, then releases the grant and counts exactly one write. It reaches contention by pointing both channels at the same request line, so that one strobe arms both in the same cycle. The end-of-run path is driven on both channels in that same contention step, which places a completion right behind a served competitor.

// File: rtl/dmac_pkg.sv
// Shared constants and types for the two-channel DMA engine.
package dmac_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int SEL_W  = 5;
    localparam int NUM_CH = 2;

    // Configuration field codes.
    typedef enum logic [2:0] {
        F_CTRL = 3'd0,
        F_SEL  = 3'd1,
        F_SRC  = 3'd2,
        F_DST  = 3'd3,
        F_OFS  = 3'd4,
        F_CNT  = 3'd5
    } field_e;

    // Bus sequencer phases.
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_READ,
        SQ_WRITE
    } seq_e;
endpackage

// File: rtl/dma_channel.sv
// One DMA channel: configuration state, a single pending-request latch,
// the advancing offset and the run counter with reload.
// Assumes start_i is raised only while pend_o is high and that finish_i
// marks the write cycle of this channel's transfer.
module dma_channel
    import dmac_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int SW = SEL_W,
    localparam int NR = 1 << SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_hit,
    input  logic [2:0]    cfg_field,
    input  logic [AW-1:0] cfg_data,
    input  logic [NR-1:0] req_in,
    input  logic          start_i,
    input  logic          finish_i,
    output logic          pend_o,
    output logic          done_o,
    output logic          word_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] wr_addr_o
);
    logic          en_q, pend_q, done_q, word_q, sinc_q, dinc_q;
    logic [SW-1:0] sel_q;
    logic [AW-1:0] src_q, dst_q, ofs_q;
    logic [CW-1:0] cnt_q, rld_q;
    logic          ctrl_wr, term, fin_term, req_now, en_nxt, pend_nxt;
    logic [AW-1:0] step;

    // Next enable and pending state; a register write overrides completion.
    always_comb begin
        ctrl_wr  = cfg_hit && (cfg_field == F_CTRL);
        term     = (cnt_q == CW'(1));
        fin_term = finish_i && term;
        step     = word_q ? AW'(2) : AW'(1);
        req_now  = (ctrl_wr && cfg_data[4]) || req_in[sel_q];
        if (ctrl_wr)       en_nxt = cfg_data[0];
        else if (fin_term) en_nxt = 1'b0;
        else               en_nxt = en_q;
        if (!en_nxt)       pend_nxt = 1'b0;
        else if (req_now)  pend_nxt = 1'b1;
        else if (start_i)  pend_nxt = 1'b0;
        else               pend_nxt = pend_q;
    end

    // Channel state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; pend_q <= 1'b0; done_q <= 1'b0;
            word_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
            sel_q <= '0; src_q <= '0; dst_q <= '0; ofs_q <= '0;
            cnt_q <= '0; rld_q <= '0;
        end else begin
            en_q   <= en_nxt;
            pend_q <= pend_nxt;
            done_q <= fin_term;
            if (finish_i) begin
                if (term) begin
                    cnt_q <= rld_q;
                    ofs_q <= '0;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                    if (sinc_q || dinc_q) ofs_q <= ofs_q + step;
                end
            end
            if (cfg_hit) begin
                case (field_e'(cfg_field))
                    F_CTRL: begin
                        word_q <= cfg_data[1];
                        sinc_q <= cfg_data[2];
                        dinc_q <= cfg_data[3];
                    end
                    F_SEL: sel_q <= cfg_data[SW-1:0];
                    F_SRC: src_q <= cfg_data;
                    F_DST: dst_q <= cfg_data;
                    F_OFS: ofs_q <= cfg_data;
                    F_CNT: begin
                        cnt_q <= cfg_data[CW-1:0];
                        rld_q <= cfg_data[CW-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Address generation for the read and write cycles.
    always_comb begin
        rd_addr_o = src_q + (sinc_q ? ofs_q : '0);
        wr_addr_o = dst_q + (dinc_q ? ofs_q : '0);
        pend_o    = pend_q;
        done_o    = done_q;
        word_o    = word_q;
    end

    // R3: a pending request only exists on an enabled channel.
    a_r3_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> en_q);
    // R3: the sequencer starts only a channel that holds a request.
    a_r3_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> pend_q);
    // R8: the end-of-run pulse lasts one cycle.
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R8: end of run disables the channel unless software rewrote control.
    a_r8_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !$past(ctrl_wr)) |-> !en_q);
    // R8: end of run restores the counter from the reload value.
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !$past(cfg_hit)) |-> (cnt_q == rld_q));
endmodule

// File: rtl/dma_sequencer.sv
// Bus sequencer: picks the lowest-numbered pending channel, requests the
// bus, then runs one read cycle and one write cycle for that channel.
// Assumes the arbiter keeps bus_gnt high while bus_req stays high.
module dma_sequencer
    import dmac_pkg::*;
#(
    parameter int NCH = NUM_CH,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend_i,
    input  logic           bus_gnt,
    output logic           bus_req,
    output logic           rd_phase,
    output logic           wr_phase,
    output logic [CHW-1:0] sel_o,
    output logic [NCH-1:0] start_o,
    output logic [NCH-1:0] finish_o
);
    seq_e           state_q;
    logic [CHW-1:0] sel_q, pick;
    logic           go;

    // Fixed priority: the lowest index wins.
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_i[i]) pick = CHW'(i);
        end
    end

    // Phase decode and per-channel strobes.
    always_comb begin
        go       = (state_q == SQ_WAIT) && bus_gnt && pend_i[sel_q];
        bus_req  = (state_q != SQ_IDLE);
        rd_phase = (state_q == SQ_READ);
        wr_phase = (state_q == SQ_WRITE);
        sel_o    = sel_q;
        for (int i = 0; i < NCH; i++) begin
            start_o[i]  = go && (sel_q == CHW'(i));
            finish_o[i] = wr_phase && (sel_q == CHW'(i));
        end
    end

    // Phase register and channel lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            sel_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (|pend_i) begin
                    sel_q   <= pick;
                    state_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (!pend_i[sel_q]) state_q <= SQ_IDLE;
                    else if (bus_gnt)   state_q <= SQ_READ;
                end
                SQ_READ:  state_q <= SQ_WRITE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    // R2: a read cycle is always followed by the write cycle.
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_READ) |=> (state_q == SQ_WRITE));
    // R9: channel 0 is locked when it is pending at selection time.
    a_r9_low_index_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && pend_i[0]) |=> (sel_q == '0));
endmodule

// File: rtl/dual_dma_engine.sv
// Top of the two-channel cycle-steal DMA engine: routes configuration
// writes, instantiates the channels and the sequencer, and holds the
// read-to-write data latch. Assumes memory returns read data in the
// same cycle as mem_rd, with a byte placed in the low lane.
module dual_dma_engine
    import dmac_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int CW  = CNT_W,
    parameter int SW  = SEL_W,
    parameter int NCH = NUM_CH,
    localparam int NR  = 1 << SW,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [2:0]     cfg_field,
    input  logic [AW-1:0]  cfg_data,
    input  logic [NR-1:0]  req_in,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           mem_byte,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [NCH-1:0] done
);
    logic [NCH-1:0] pend, start, finish, word;
    logic [AW-1:0]  rd_a [NCH];
    logic [AW-1:0]  wr_a [NCH];
    logic [CHW-1:0] sel;
    logic           rd_phase, wr_phase;
    logic [DW-1:0]  latch_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_channel #(.AW(AW), .CW(CW), .SW(SW)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_hit   (cfg_wr && (cfg_ch == CHW'(g))),
            .cfg_field (cfg_field),
            .cfg_data  (cfg_data),
            .req_in    (req_in),
            .start_i   (start[g]),
            .finish_i  (finish[g]),
            .pend_o    (pend[g]),
            .done_o    (done[g]),
            .word_o    (word[g]),
            .rd_addr_o (rd_a[g]),
            .wr_addr_o (wr_a[g])
        );
    end

    dma_sequencer #(.NCH(NCH)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .bus_gnt  (bus_gnt),
        .bus_req  (bus_req),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase),
        .sel_o    (sel),
        .start_o  (start),
        .finish_o (finish)
    );

    // Captures the read data for the following write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (rd_phase) latch_q <= mem_rdata;
    end

    // Drives the memory port from the locked channel.
    always_comb begin
        mem_rd    = rd_phase;
        mem_wr    = wr_phase;
        mem_byte  = !word[sel];
        mem_addr  = rd_phase ? rd_a[sel] : wr_a[sel];
        mem_wdata = word[sel] ? latch_q : {{(DW-8){1'b0}}, latch_q[7:0]};
    end

    // R2: reads and writes never share a cycle.
    a_r2_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R2: memory cycles only while the bus is requested.
    a_r2_bus_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_req);
    // R2: every write cycle directly follows a read cycle.
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));
endmodule

// File: tb/dual_dma_engine_tb_top.sv
`timescale 1ns/1ps
module dual_dma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [2:0]  cfg_field = '0;
    logic [19:0] cfg_data = '0;
    logic [31:0] req_in = '0;
    logic        bus_req, bus_gnt, mem_rd, mem_wr, mem_byte;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0]  done;
    logic        gnt_open = 1'b1;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int done_cnt [2];
    bit finished = 0;

    typedef struct {
        logic [19:0] a;
        logic [15:0] d;
        logic        b;
    } exp_t;
    exp_t exp_q [$];
    exp_t mon_e;

    logic [7:0] mem [0:4095];

    always #2 clk = ~clk;

    assign bus_gnt = bus_req && gnt_open;

    dual_dma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .req_in(req_in),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_byte(mem_byte),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    function automatic logic [7:0] initb(input int a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [15:0] initw(input int a);
        return {initb(a + 1), initb(a)};
    endfunction

    // Memory model: combinational read, byte or word write at the edge.
    always_comb begin
        if (mem_byte) mem_rdata = {8'h00, mem[mem_addr[11:0]]};
        else          mem_rdata = {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
    end

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[11:0]] <= mem_wdata[7:0];
            if (!mem_byte) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input logic [2:0] f, input logic [19:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_ch = 1'(ch); cfg_field = f; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        req_in = 32'(1) << idx;
        @(negedge clk);
        req_in = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_wr(input logic [19:0] a, input logic [15:0] d, input logic b);
        exp_t e;
        e.a = a; e.d = d; e.b = b;
        exp_q.push_back(e);
    endtask

    // Monitor: pops the scoreboard on every write cycle, counts done pulses.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_wr) begin
                wr_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R3 unexpected write", {12'h0, mem_addr}, 32'h0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(mem_addr == mon_e.a, "R7 write address", {12'h0, mem_addr}, {12'h0, mon_e.a});
                    chk(mem_wdata == mon_e.d, "R2/R6 write data", {16'h0, mem_wdata}, {16'h0, mon_e.d});
                    chk(mem_byte == mon_e.b, "R6 transfer size", {31'h0, mem_byte}, {31'h0, mon_e.b});
                end
            end
            for (int i = 0; i < 2; i++) if (done[i]) done_cnt[i]++;
        end
    end

    initial begin
        int w0;
        done_cnt[0] = 0; done_cnt[1] = 0;
        for (int i = 0; i < 4096; i++) mem[i] = initb(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bus_req == 1'b0, "R1 bus_req after reset", {31'h0, bus_req}, 32'h0);
        chk(!mem_rd && !mem_wr, "R1 memory idle after reset", {30'h0, mem_rd, mem_wr}, 32'h0);
        chk(done == 2'b00, "R1 done after reset", {30'h0, done}, 32'h0);
        pulse(0);
        settle(8);
        chk(wr_cnt == 0, "R1 disabled channels ignore requests", wr_cnt, 0);

        // R10/R7: channel 0 word run, both sides increment, three transfers
        cfg(0, 3'd2, 20'h00100);
        cfg(0, 3'd3, 20'h00800);
        cfg(0, 3'd5, 20'd3);
        cfg(0, 3'd0, 20'b01111);
        for (int k = 0; k < 3; k++) begin
            expect_wr(20'h00800 + 20'(2 * k), initw(32'h100 + 2 * k), 1'b0);
            cfg(0, 3'd0, 20'b11111);
            settle(8);
        end
        chk(wr_cnt == 3, "R2 one write per trigger", wr_cnt, 3);
        chk(done_cnt[0] == 1, "R8 done pulse at end of run", done_cnt[0], 1);
        // R3: channel 0 was disabled by the end of run; its line 0 request is dropped
        w0 = wr_cnt;
        pulse(0);
        settle(8);
        chk(wr_cnt == w0, "R3 request on disabled channel", wr_cnt, w0);
        chk(bus_req == 1'b0, "R3 no bus request when disabled", {31'h0, bus_req}, 32'h0);

        // R8: re-enable; counter and offset were restored
        expect_wr(20'h00800, initw(32'h100), 1'b0);
        cfg(0, 3'd0, 20'b11111);
        settle(8);

        // R4/R6: channel 1 byte mode, fixed source, increment destination, line 19
        cfg(1, 3'd2, 20'h00200);
        cfg(1, 3'd3, 20'h00900);
        cfg(1, 3'd5, 20'd5);
        cfg(1, 3'd1, 20'd19);
        cfg(1, 3'd0, 20'b01001);
        w0 = wr_cnt;
        pulse(18);
        settle(8);
        chk(wr_cnt == w0, "R4 unselected line ignored", wr_cnt, w0);
        expect_wr(20'h00900, {8'h00, initb(32'h200)}, 1'b1);
        pulse(19);
        settle(8);
        expect_wr(20'h00901, {8'h00, initb(32'h200)}, 1'b1);
        pulse(19);
        settle(8);
        chk(wr_cnt == w0 + 2, "R4 selected line transfers", wr_cnt, w0 + 2);

        // R5/R2: grant withheld while three requests arrive
        gnt_open = 1'b0;
        w0 = wr_cnt;
        pulse(19); pulse(19); pulse(19);
        settle(4);
        chk(bus_req == 1'b1, "R2 bus request held while waiting", {31'h0, bus_req}, 32'h1);
        chk(mem_rd == 1'b0, "R2 no read before grant", {31'h0, mem_rd}, 32'h0);
        expect_wr(20'h00902, {8'h00, initb(32'h200)}, 1'b1);
        gnt_open = 1'b1;
        settle(10);
        chk(wr_cnt == w0 + 1, "R5 merged requests give one transfer", wr_cnt, w0 + 1);

        // R9: both channels armed by one strobe; channel 0 goes first
        cfg(0, 3'd1, 20'd19);
        expect_wr(20'h00802, initw(32'h102), 1'b0);
        expect_wr(20'h00903, {8'h00, initb(32'h200)}, 1'b1);
        pulse(19);
        while (!mem_rd) @(negedge clk);
        chk(mem_addr == 20'h00102, "R9 channel 0 read first", {12'h0, mem_addr}, 32'h00102);
        settle(12);

        // R8: last transfer on both channels
        expect_wr(20'h00804, initw(32'h104), 1'b0);
        expect_wr(20'h00904, {8'h00, initb(32'h200)}, 1'b1);
        pulse(19);
        settle(14);
        chk(done_cnt[0] == 2, "R8 channel 0 second run ends", done_cnt[0], 2);
        chk(done_cnt[1] == 1, "R8 channel 1 run ends", done_cnt[1], 1);
        w0 = wr_cnt;
        pulse(19);
        settle(8);
        chk(wr_cnt == w0, "R3 both channels disabled after run", wr_cnt, w0);
        chk(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule